// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Flag Register

This block holds one 64-bit control and status word for a four-processor system. The word carries a timer interrupt flag and an interprocessor interrupt flag for each processor. It also carries two small arbitration fields and a four-bit plain read/write field. Software reaches the word over a 32-bit CSR port. A 64-bit write is made in two steps. The lower half is written first and is held. The upper half is written next, and that write commits all 64 bits in one cycle. Different bit ranges follow different write rules. Some clear when written with a one. Some set when written with a one. One field sets only while it currently reads zero. A request field raises the interprocessor flags but is never stored.

A read of the lower half returns the stored bits with the requesting processor's index in bits 1:0. The same read snapshots the upper half, so a following read of the upper half returns a consistent 64-bit value. Each processor has an interprocessor interrupt line, which follows its flag. Each processor also has a timer line. A per-processor tick strobe sets a timer flag and raises that line. Only a committing write can lower a timer line.

Top module: `ipictl_top`

## Requirements
- R1: After a synchronous active-low reset, every stored bit is zero and all eight interrupt outputs are low. A lower-half read then returns only the processor index in bits 1:0.
- R2: A write with `csrHigh`=0 only holds its data and changes no stored bit or output. A write with `csrHigh`=1 commits the 64-bit value formed from its data (bits 63:32) and the last held lower half (bits 31:0).
- R3: On a commit, a one in any of bits 11:4 or bit 28 clears that stored bit, and a zero leaves it unchanged. Bits 7:4 are the timer flags of processors 0..3, and bits 11:8 are the interprocessor flags of processors 0..3.
- R4: On a commit, a one in bit 12+i sets interprocessor flag bit 8+i. This set wins over a clear of the same flag in the same write. Bits 15:12 always read zero.
- R5: On a commit whose bit 20 is one, stored bits 23:16 become zero.
- R6: On a commit whose bit 20 is zero, ones in bits 23:20 set those stored bits.
- R7: On a commit whose bit 20 is zero, ones in bits 19:16 set those stored bits, but only if stored bits 19:16 were all zero before the write. Otherwise the field is unchanged.
- R8: Bits 43:40 take the written value on each commit. All bits not named in R3 to R8 read zero.
- R9: A lower-half read returns stored bits 31:0 ORed with `csrCpuId` in bits 1:0, in the same cycle. It also snapshots bits 63:32. An upper-half read returns that snapshot, not the current upper half.
- R10: `ipiIrq[i]` equals interprocessor flag bit 8+i. It changes only in the cycle after a commit.
- R11: `tickSet[i]` sets timer flag bit 4+i and raises `timerIrq[i]` in the next cycle. `timerIrq[i]` falls only after a commit that clears its flag.
- R12: When a tick and a commit that clears the same timer flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csrWrEn | input | 1 | Write strobe, one cycle per half |
| csrRdEn | input | 1 | Read strobe |
| csrHigh | input | 1 | 1 selects the upper half (bits 63:32) |
| csrWrData | input | 32 | Write data for the selected half |
| csrCpuId | input | 2 | Index of the processor making the access |
| csrRdData | output | 32 | Read data, valid in the cycle of csrRdEn |
| tickSet | input | 4 | Per-processor timer tick strobe |
| ipiIrq | output | 4 | Interprocessor interrupt line per processor |
| timerIrq | output | 4 | Timer interrupt line per processor |

## Verification
The interrupt lines are driven straight from the stored flags. A wrong flag therefore appears on `ipiIrq` or `timerIrq` in the cycle after the commit or tick that produced it. A corrupted arbitration or read/write field produces no output activity. It shows only at the next lower-half or upper-half read, so every write scenario is followed by a read. A stale or wrong upper-half snapshot shows only when the upper half changes between a lower read and an upper read. That case is provoked on purpose.

// File: rtl/ipictl_pkg.sv
package ipictl_pkg;
  localparam int NUM_CPU   = 4;
  localparam int CSR_W     = 32;
  localparam int REG_W     = 2 * CSR_W;
  localparam int IDX_W     = $clog2(NUM_CPU);
  localparam int ITI_LSB   = 4;
  localparam int IPI_LSB   = ITI_LSB + NUM_CPU;
  localparam int REQ_LSB   = IPI_LSB + NUM_CPU;
  localparam int ARBW_LSB  = 16;
  localparam int ARBW_W    = 4;
  localparam int ARBT_LSB  = ARBW_LSB + ARBW_W;
  localparam int ARBT_W    = 4;
  localparam int CLRALL_BIT = ARBT_LSB;
  localparam int STICKY_BIT = 28;
  localparam int RW_LSB    = 40;
  localparam int RW_W      = 4;
  localparam logic [REG_W-1:0] CPU_ONES = REG_W'((1 << NUM_CPU) - 1);
  localparam logic [REG_W-1:0] W1C_MASK =
      (CPU_ONES << ITI_LSB) | (CPU_ONES << IPI_LSB) | (REG_W'(1) << STICKY_BIT);

  typedef struct packed {
    logic captureLow;
    logic commit;
    logic snapRead;
    logic readHigh;
  } busStrobe_t;
endpackage

// File: rtl/ipictl_ctrl.sv
module ipictl_ctrl
  import ipictl_pkg::*;
(
  input  logic       csrWrEn,
  input  logic       csrRdEn,
  input  logic       csrHigh,
  output busStrobe_t stb
);
  always_comb begin
    stb.captureLow = csrWrEn && !csrHigh;
    stb.commit     = csrWrEn && csrHigh;
    stb.snapRead   = csrRdEn && !csrHigh;
    stb.readHigh   = csrHigh;
  end
endmodule

// File: rtl/ipictl_datapath.sv
module ipictl_datapath
  import ipictl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         stb,
  input  logic [CSR_W-1:0]   wrData,
  input  logic [IDX_W-1:0]   cpuId,
  input  logic [NUM_CPU-1:0] tickSet,
  output logic [CSR_W-1:0]   rdData,
  output logic [NUM_CPU-1:0] ipiFlags,
  output logic [NUM_CPU-1:0] itiFlags
);
  logic [REG_W-1:0] regQ, regNext, wordIn;
  logic [CSR_W-1:0] holdQ, snapQ, lowView;

  assign wordIn = {wrData, holdQ};

  always_comb begin
    regNext = regQ;
    if (stb.commit) begin
      regNext = regQ & ~(wordIn & W1C_MASK);
      if (wordIn[CLRALL_BIT]) begin
        regNext[ARBW_LSB +: ARBW_W + ARBT_W] = '0;
      end else begin
        regNext[ARBT_LSB +: ARBT_W] = regQ[ARBT_LSB +: ARBT_W] | wordIn[ARBT_LSB +: ARBT_W];
        if (regQ[ARBW_LSB +: ARBW_W] == '0)
          regNext[ARBW_LSB +: ARBW_W] = wordIn[ARBW_LSB +: ARBW_W];
      end
      regNext[IPI_LSB +: NUM_CPU] = regNext[IPI_LSB +: NUM_CPU] | wordIn[REQ_LSB +: NUM_CPU];
      regNext[RW_LSB +: RW_W] = wordIn[RW_LSB +: RW_W];
    end
    regNext[ITI_LSB +: NUM_CPU] = regNext[ITI_LSB +: NUM_CPU] | tickSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ  <= '0;
      holdQ <= '0;
      snapQ <= '0;
    end else begin
      regQ <= regNext;
      if (stb.captureLow) holdQ <= wrData;
      if (stb.snapRead)   snapQ <= regQ[REG_W-1:CSR_W];
    end
  end

  assign lowView  = regQ[CSR_W-1:0] | CSR_W'(cpuId);
  assign rdData   = stb.readHigh ? snapQ : lowView;
  assign ipiFlags = regQ[IPI_LSB +: NUM_CPU];
  assign itiFlags = regQ[ITI_LSB +: NUM_CPU];
endmodule

// File: rtl/ipictl_top.sv
module ipictl_top
  import ipictl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWrEn,
  input  logic        csrRdEn,
  input  logic        csrHigh,
  input  logic [31:0] csrWrData,
  input  logic [1:0]  csrCpuId,
  output logic [31:0] csrRdData,
  input  logic [3:0]  tickSet,
  output logic [3:0]  ipiIrq,
  output logic [3:0]  timerIrq
);
  busStrobe_t stb;

  ipictl_ctrl u_ctrl (
    .csrWrEn(csrWrEn),
    .csrRdEn(csrRdEn),
    .csrHigh(csrHigh),
    .stb    (stb)
  );

  ipictl_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (csrWrData),
    .cpuId   (csrCpuId),
    .tickSet (tickSet),
    .rdData  (csrRdData),
    .ipiFlags(ipiIrq),
    .itiFlags(timerIrq)
  );
endmodule

// File: rtl/ipictl_checker.sv
module ipictl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        csrWrEn,
  input logic        csrRdEn,
  input logic        csrHigh,
  input logic [1:0]  csrCpuId,
  input logic [31:0] csrRdData,
  input logic [3:0]  tickSet,
  input logic [3:0]  ipiIrq,
  input logic [3:0]  timerIrq
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (ipiIrq == 4'b0 && timerIrq == 4'b0));

  a_r10_ipi_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ipiIrq) |-> $past(csrWrEn && csrHigh));

  // R11 and R12: a tick always leaves its flag set, even during a commit
  a_r11_tick_sets: assert property (@(posedge clk) disable iff (!rstN)
    (tickSet != 4'b0) |=> ((timerIrq & $past(tickSet)) == $past(tickSet)));

  a_r11_timer_fall: assert property (@(posedge clk) disable iff (!rstN)
    ((~timerIrq & $past(timerIrq)) != 4'b0) |-> $past(csrWrEn && csrHigh));

  a_r9_cpu_index: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdEn && !csrHigh) |-> (csrRdData[1:0] == csrCpuId));
endmodule

bind ipictl_top ipictl_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csrWrEn  (csrWrEn),
  .csrRdEn  (csrRdEn),
  .csrHigh  (csrHigh),
  .csrCpuId (csrCpuId),
  .csrRdData(csrRdData),
  .tickSet  (tickSet),
  .ipiIrq   (ipiIrq),
  .timerIrq (timerIrq)
);

// File: tb/ipictl_top_bench.sv
module ipictl_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0, csrRdEn = 1'b0, csrHigh = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [1:0]  csrCpuId = '0;
  logic [31:0] csrRdData;
  logic [3:0]  tickSet = '0;
  logic [3:0]  ipiIrq, timerIrq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipictl_top u_ipictl_top (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn),
    .csrHigh(csrHigh), .csrWrData(csrWrData), .csrCpuId(csrCpuId),
    .csrRdData(csrRdData), .tickSet(tickSet), .ipiIrq(ipiIrq), .timerIrq(timerIrq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr64(input logic [63:0] v, input logic [3:0] tk);
    @(negedge clk); csrWrEn = 1; csrHigh = 0; csrWrData = v[31:0];
    @(negedge clk); csrHigh = 1; csrWrData = v[63:32]; tickSet = tk;
    @(negedge clk); csrWrEn = 0; csrHigh = 0; tickSet = 0;
  endtask

  task automatic wrHighOnly(input logic [31:0] v);
    @(negedge clk); csrWrEn = 1; csrHigh = 1; csrWrData = v;
    @(negedge clk); csrWrEn = 0; csrHigh = 0;
  endtask

  task automatic rdLo(input logic [1:0] id, output logic [31:0] lo);
    @(negedge clk); csrRdEn = 1; csrHigh = 0; csrCpuId = id;
    #1 lo = csrRdData;
    @(negedge clk); csrRdEn = 0;
  endtask

  task automatic rdHi(output logic [31:0] hi);
    @(negedge clk); csrRdEn = 1; csrHigh = 1;
    #1 hi = csrRdData;
    @(negedge clk); csrRdEn = 0; csrHigh = 0;
  endtask

  task automatic pulseTick(input logic [3:0] tk);
    @(negedge clk); tickSet = tk;
    @(negedge clk); tickSet = 0;
  endtask

  task automatic t_reset();
    logic [31:0] lo, hi;
    check("R1 ipi", 64'(ipiIrq), 0);
    check("R1 timer", 64'(timerIrq), 0);
    rdLo(2'd2, lo); rdHi(hi);
    check("R1 low read", 64'(lo), 64'h2);
    check("R1 high read", 64'(hi), 0);
  endtask

  task automatic t_twoPhase();
    @(negedge clk); csrWrEn = 1; csrHigh = 0; csrWrData = 32'h0000_F000;
    @(negedge clk); csrWrEn = 0;
    repeat (2) @(negedge clk);
    check("R2 low half alone", 64'(ipiIrq), 0);
    wrHighOnly(32'h0);
    check("R2 commit uses held low", 64'(ipiIrq), 64'hF);
  endtask

  task automatic t_clear();
    logic [31:0] lo;
    wr64(64'h500, 4'h0);
    check("R3 ipi clear", 64'(ipiIrq), 64'hA);
    check("R10 ipi line", 64'(ipiIrq), 64'hA);
    rdLo(2'd1, lo);
    check("R3 low read", 64'(lo), 64'h0A01);
  endtask

  task automatic t_request();
    logic [31:0] lo;
    wr64(64'h2200, 4'h0);
    check("R4 request beats clear", 64'(ipiIrq), 64'hA);
    rdLo(2'd0, lo);
    check("R4 request bits read zero", 64'(lo), 64'h0A00);
  endtask

  task automatic t_tick();
    logic [31:0] lo;
    pulseTick(4'h5);
    check("R11 tick raises timer", 64'(timerIrq), 64'h5);
    rdLo(2'd0, lo);
    check("R11 flags read", 64'(lo), 64'h0A50);
    wr64(64'h10, 4'h0);
    check("R11 clear lowers timer", 64'(timerIrq), 64'h4);
    wr64(64'h0, 4'h0);
    check("R11 no clear keeps timer", 64'(timerIrq), 64'h4);
  endtask

  task automatic t_sameCycle();
    wr64(64'h40, 4'h4);
    check("R12 tick beats clear", 64'(timerIrq), 64'h4);
  endtask

  task automatic t_fields();
    logic [31:0] lo;
    wr64(64'h00E0_0000, 4'h0);
    rdLo(2'd0, lo);
    check("R6 upper field set", 64'(lo), 64'h00E0_0A40);
    wr64(64'h000A_0000, 4'h0);
    rdLo(2'd0, lo);
    check("R7 set while zero", 64'(lo), 64'h00EA_0A40);
    wr64(64'h0005_0000, 4'h0);
    rdLo(2'd0, lo);
    check("R7 no set when nonzero", 64'(lo), 64'h00EA_0A40);
    wr64(64'h0010_0000, 4'h0);
    rdLo(2'd0, lo);
    check("R5 clear-all", 64'(lo), 64'h0000_0A40);
  endtask

  task automatic t_rw();
    logic [31:0] lo, hi;
    wr64({32'hFFFF_FFFF, 32'h0}, 4'h0);
    rdLo(2'd0, lo); rdHi(hi);
    check("R8 rw field only", 64'(hi), 64'h0F00);
    check("R8 low unchanged", 64'(lo), 64'h0A40);
    wr64({32'h0000_0500, 32'h0}, 4'h0);
    rdLo(2'd0, lo); rdHi(hi);
    check("R8 rw rewrite", 64'(hi), 64'h0500);
    wr64({32'h0000_0500, 32'hFFFF_FFFF}, 4'h0);
    rdLo(2'd0, lo);
    check("R3 R4 R8 all ones low", 64'(lo), 64'h0F00);
    check("R3 timer cleared", 64'(timerIrq), 0);
    check("R4 ipi set", 64'(ipiIrq), 64'hF);
  endtask

  task automatic t_snapshot();
    logic [31:0] lo, hi;
    rdLo(2'd3, lo);
    check("R9 cpu index", 64'(lo), 64'h0F03);
    wr64({32'h0000_0300, 32'h0}, 4'h0);
    rdHi(hi);
    check("R9 high read is snapshot", 64'(hi), 64'h0500);
    rdLo(2'd0, lo); rdHi(hi);
    check("R9 fresh snapshot", 64'(hi), 64'h0300);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
          checks++; fails++;
          $display("FAIL watchdog actual=running expected=done");
          $display("%0d/%0d checks passed", checks - fails, checks);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_twoPhase();
    t_clear();
    t_request();
    t_tick();
    t_sameCycle();
    t_fields();
    t_rw();
    t_snapshot();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule